// File: doc/BRIEF.md
# Dual-Channel Payload Router

This block sits between two upstream payload FIFOs and a packing stage. It decides for each word whether to send it on uncoded or to hand it to the network-coding path. If only one of the two FIFOs holds data, that word is popped and written to the packing FIFO on the uncoded bus. If both hold data in the same cycle, the router pops both together and presents the pair on the coded buses for the coding arithmetic that follows.

Each output word is 73 bits wide: a 64-bit payload, a flag bit directly above it that marks the word as coded (1) or uncoded (0), and eight zero bits on top. The FIFOs have a read latency of one cycle. A popped word is captured into a holding register and stays there until the ready input of its path allows the write. A 3-bit state code is brought out so that the packing logic can follow the router's progress.

Top module: `payload_router`

## Requirements
- R1: While `rst_n` is low and at the first cycle after it, `state` is 0 and `a_rd_en`, `b_rd_en`, `plain_wr_en` and `code_wr_en` are all 0.
- R2: When both FIFOs are non-empty, `code_ready` is 1 and the router is idle, `a_rd_en` and `b_rd_en` are asserted in the same cycle. While both FIFOs are non-empty, one read enable is never asserted without the other.
- R3: When only FIFO A is non-empty and `plain_ready` is 1, A alone is read. Two cycles later its word appears on `plain_data` as {8'h00, 1'b0, payload}.
- R4: When only FIFO B is non-empty and `plain_ready` is 1, B alone is read. Its word appears on `plain_data` in the same format and with the same timing as in R3.
- R5: A coded pair is written with a single pulse of `code_wr_en`. `code_data_a` carries {8'h00, 1'b1, A payload} and `code_data_b` carries {8'h00, 1'b1, B payload}.
- R6: `plain_wr_en` is 1 only while `plain_ready` is 1, and `code_wr_en` is 1 only while `code_ready` is 1.
- R7: No read is started while the ready input of the path that read would feed is 0. No read is started while a word is held waiting to be written.
- R8: `state` encodes idle = 0, single read from A = 1, single read from B = 2, paired read = 3 and holding = 4. Each word moves through idle, then its read code, then 4, then back to idle.
- R9: A read enable is never asserted while the matching FIFO's empty flag is 1.
- R10: Every word that is read is written exactly once, in the order it was read. It stays in the holding register, unchanged, for as long as its path's ready input is 0.
- R11: When both FIFOs are non-empty but `code_ready` is 0, the router stalls with no reads at all. It does not fall back to the uncoded path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_empty | input | 1 | FIFO A empty flag |
| a_rdata | input | 64 | FIFO A read data, valid one cycle after a read |
| a_rd_en | output | 1 | FIFO A read enable |
| b_empty | input | 1 | FIFO B empty flag |
| b_rdata | input | 64 | FIFO B read data, valid one cycle after a read |
| b_rd_en | output | 1 | FIFO B read enable |
| plain_ready | input | 1 | Packing FIFO can accept an uncoded word |
| plain_wr_en | output | 1 | Uncoded word write strobe |
| plain_data | output | 73 | Uncoded word, flag bit 64 = 0 |
| code_ready | input | 1 | Coding path can accept a pair |
| code_wr_en | output | 1 | Coded pair write strobe |
| code_data_a | output | 73 | Coded lane A word, flag bit 64 = 1 |
| code_data_b | output | 73 | Coded lane B word, flag bit 64 = 1 |
| state | output | 3 | Router state code (see R8) |

## Verification
The assertions check the rules that hold in every cycle. Writes only happen under ready. An empty FIFO is never read. While both FIFOs are non-empty, one side is never read alone. A read is started only when its target path is ready. At most one word is in flight, and every write is preceded by a read. The flag and pad bits of each bus are checked on every write. The bench scenarios cover what a per-cycle rule cannot: the exact payloads and their order through the scoreboard, the state sequence of each read kind, a held word surviving a ready drop unchanged, and the stall when coding is blocked while plain output is still free.

// File: rtl/router_pkg.sv
// Shared types for the dual-channel payload router.
// Assumes a 3-bit state code that downstream packing logic decodes.
package router_pkg;

    // Router state; values are visible on the state output port.
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_TAKE_A    = 3'd1,
        ST_TAKE_B    = 3'd2,
        ST_TAKE_PAIR = 3'd3,
        ST_HOLD      = 3'd4
    } rt_state_e;

    // Read decision made in the idle state.
    typedef enum logic [1:0] {
        PICK_NONE,
        PICK_A,
        PICK_B,
        PICK_PAIR
    } pick_e;

    localparam int unsigned NUM_LANES = 2;

endpackage

// File: rtl/router_pick.sv
// Read decision logic.
// Chooses which FIFO(s) to pop in the idle state. A pair is taken only when both
// FIFOs hold data and the coding path is ready; a single channel is taken only
// when the other FIFO is empty and the plain path is ready. Channel A is tested
// before channel B. Purely combinational.
module router_pick
    import router_pkg::*;
(
    input  logic  idle,
    input  logic  a_empty,
    input  logic  b_empty,
    input  logic  plain_ready,
    input  logic  code_ready,
    output pick_e pick
);

    // Decide this cycle's read, stalling when the target path is not ready.
    always_comb begin
        pick = PICK_NONE;
        if (idle) begin
            if (!a_empty && !b_empty) begin
                if (code_ready) pick = PICK_PAIR;
            end else if (!a_empty) begin
                if (plain_ready) pick = PICK_A;
            end else if (!b_empty) begin
                if (plain_ready) pick = PICK_B;
            end
        end
    end

endmodule

// File: rtl/router_fsm.sv
// Router state register.
// Moves idle -> read -> hold -> idle; the read state lasts one cycle (FIFO
// read latency), the hold state lasts until the held word is written.
// Assumes a synchronous active-low reset.
module router_fsm
    import router_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pick_e     pick,
    input  logic      word_taken,
    output rt_state_e state_q
);

    rt_state_e state_d;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                unique case (pick)
                    PICK_A:    state_d = ST_TAKE_A;
                    PICK_B:    state_d = ST_TAKE_B;
                    PICK_PAIR: state_d = ST_TAKE_PAIR;
                    default:   state_d = ST_IDLE;
                endcase
            end
            ST_TAKE_A, ST_TAKE_B, ST_TAKE_PAIR: state_d = ST_HOLD;
            ST_HOLD: if (word_taken) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/router_hold.sv
// Holding register for the word(s) popped from the FIFOs.
// Captures one payload per lane when capture is high and keeps it until the
// next capture; also records whether the held content is a coded pair.
module router_hold
    import router_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                capture,
    input  logic                                capture_coded,
    input  logic [NUM_LANES-1:0][DATA_W-1:0]    lane_in,
    output logic [NUM_LANES-1:0][DATA_W-1:0]    lane_q,
    output logic                                coded_q
);

    // One payload register per lane.
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)       lane_q[i] <= '0;
            else if (capture) lane_q[i] <= lane_in[i];
        end
    end

    // Coded/uncoded marker for the held content.
    always_ff @(posedge clk) begin
        if (!rst_n)       coded_q <= 1'b0;
        else if (capture) coded_q <= capture_coded;
    end

endmodule

// File: rtl/payload_router.sv
// Dual-channel payload router (top).
// Pops one FIFO for an uncoded word or both for a coded pair, holds the result
// and writes it to the plain or coded output once that path is ready.
// Assumes FIFOs with one cycle read latency and a synchronous active-low reset.
module payload_router
    import router_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned BUS_W  = 73
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_empty,
    input  logic [DATA_W-1:0] a_rdata,
    output logic             a_rd_en,
    input  logic             b_empty,
    input  logic [DATA_W-1:0] b_rdata,
    output logic             b_rd_en,
    input  logic             plain_ready,
    output logic             plain_wr_en,
    output logic [BUS_W-1:0] plain_data,
    input  logic             code_ready,
    output logic             code_wr_en,
    output logic [BUS_W-1:0] code_data_a,
    output logic [BUS_W-1:0] code_data_b,
    output logic [2:0]       state
);

    localparam int unsigned PAD_W = BUS_W - DATA_W - 1;

    rt_state_e                           st;
    pick_e                               pick;
    logic                                held_coded;
    logic                                taken;
    logic                                capture;
    logic [NUM_LANES-1:0][DATA_W-1:0]    lane_in;
    logic [NUM_LANES-1:0][DATA_W-1:0]    lane_q;

    router_pick u_pick (
        .idle        (st == ST_IDLE),
        .a_empty     (a_empty),
        .b_empty     (b_empty),
        .plain_ready (plain_ready),
        .code_ready  (code_ready),
        .pick        (pick)
    );

    router_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pick       (pick),
        .word_taken (taken),
        .state_q    (st)
    );

    // Route FIFO data into the hold lanes; lane 0 carries the single word.
    always_comb begin
        capture    = (st == ST_TAKE_A) || (st == ST_TAKE_B) || (st == ST_TAKE_PAIR);
        lane_in[0] = (st == ST_TAKE_B) ? b_rdata : a_rdata;
        lane_in[1] = b_rdata;
    end

    router_hold #(.DATA_W(DATA_W)) u_hold (
        .clk           (clk),
        .rst_n         (rst_n),
        .capture       (capture),
        .capture_coded (st == ST_TAKE_PAIR),
        .lane_in       (lane_in),
        .lane_q        (lane_q),
        .coded_q       (held_coded)
    );

    // Read enables, write strobes and tagged output buses.
    always_comb begin
        a_rd_en     = (pick == PICK_A) || (pick == PICK_PAIR);
        b_rd_en     = (pick == PICK_B) || (pick == PICK_PAIR);
        plain_wr_en = (st == ST_HOLD) && !held_coded && plain_ready;
        code_wr_en  = (st == ST_HOLD) &&  held_coded && code_ready;
        taken       = plain_wr_en || code_wr_en;
        plain_data  = {{PAD_W{1'b0}}, 1'b0, lane_q[0]};
        code_data_a = {{PAD_W{1'b0}}, 1'b1, lane_q[0]};
        code_data_b = {{PAD_W{1'b0}}, 1'b1, lane_q[1]};
        state       = st;
    end

endmodule

// File: rtl/payload_router_chk.sv
// Assertion checker for payload_router, attached by bind.
// Sees only the top-level ports (flag/pad slices of the buses).
module payload_router_chk #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned BUS_W  = 73
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    a_empty,
    input logic                    b_empty,
    input logic                    a_rd_en,
    input logic                    b_rd_en,
    input logic                    plain_ready,
    input logic                    plain_wr_en,
    input logic [BUS_W-DATA_W-1:0] plain_tag,
    input logic                    code_ready,
    input logic                    code_wr_en,
    input logic [BUS_W-DATA_W-1:0] code_tag_a,
    input logic [BUS_W-DATA_W-1:0] code_tag_b,
    input logic [2:0]              state
);

    localparam int unsigned TAG_W = BUS_W - DATA_W;
    localparam logic [TAG_W-1:0] CODED_TAG = {{(TAG_W-1){1'b0}}, 1'b1};

    logic pend;

    // Tracks a word popped but not yet written.
    always_ff @(posedge clk) begin
        if (!rst_n)                         pend <= 1'b0;
        else if (a_rd_en || b_rd_en)        pend <= 1'b1;
        else if (plain_wr_en || code_wr_en) pend <= 1'b0;
    end

    a_r2_no_lone_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_empty && !b_empty) |-> (a_rd_en == b_rd_en));
    a_r3_plain_tag: assert property (@(posedge clk) disable iff (!rst_n)
        plain_wr_en |-> (plain_tag == '0));
    a_r5_code_tag: assert property (@(posedge clk) disable iff (!rst_n)
        code_wr_en |-> (code_tag_a == CODED_TAG && code_tag_b == CODED_TAG));
    a_r6_plain_ready: assert property (@(posedge clk) disable iff (!rst_n)
        plain_wr_en |-> plain_ready);
    a_r6_code_ready: assert property (@(posedge clk) disable iff (!rst_n)
        code_wr_en |-> code_ready);
    a_r6_one_path: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({plain_wr_en, code_wr_en}) <= 1);
    a_r7_single_needs_plain: assert property (@(posedge clk) disable iff (!rst_n)
        (a_rd_en != b_rd_en) |-> plain_ready);
    a_r7_pair_needs_code: assert property (@(posedge clk) disable iff (!rst_n)
        (a_rd_en && b_rd_en) |-> code_ready);
    a_r7_no_read_while_held: assert property (@(posedge clk) disable iff (!rst_n)
        (a_rd_en || b_rd_en) |-> !pend);
    a_r8_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
        state <= 3'd4);
    a_r9_a_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        a_rd_en |-> !a_empty);
    a_r9_b_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        b_rd_en |-> !b_empty);
    a_r10_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_wr_en || code_wr_en) |-> pend);

endmodule

bind payload_router payload_router_chk #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .a_empty     (a_empty),
    .b_empty     (b_empty),
    .a_rd_en     (a_rd_en),
    .b_rd_en     (b_rd_en),
    .plain_ready (plain_ready),
    .plain_wr_en (plain_wr_en),
    .plain_tag   (plain_data[BUS_W-1:DATA_W]),
    .code_ready  (code_ready),
    .code_wr_en  (code_wr_en),
    .code_tag_a  (code_data_a[BUS_W-1:DATA_W]),
    .code_tag_b  (code_data_b[BUS_W-1:DATA_W]),
    .state       (state)
);

// File: tb/payload_router_bench.sv
module payload_router_bench;

    typedef struct packed {
        logic        coded;
        logic [63:0] a;
        logic [63:0] b;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_empty = 1'b1, b_empty = 1'b1;
    logic [63:0] a_rdata = '0, b_rdata = '0;
    logic        a_rd_en, b_rd_en;
    logic        plain_ready = 1'b0, code_ready = 1'b0;
    logic        plain_wr_en, code_wr_en;
    logic [72:0] plain_data, code_data_a, code_data_b;
    logic [2:0]  state;

    int   total = 0;
    int   bad = 0;
    int   cyc = 0;
    bit   done = 0;
    logic [63:0] qa[$];
    logic [63:0] qb[$];
    exp_t        exp_q[$];

    always #2.5 clk = ~clk;

    payload_router u_payload_router (
        .clk(clk), .rst_n(rst_n),
        .a_empty(a_empty), .a_rdata(a_rdata), .a_rd_en(a_rd_en),
        .b_empty(b_empty), .b_rdata(b_rdata), .b_rd_en(b_rd_en),
        .plain_ready(plain_ready), .plain_wr_en(plain_wr_en), .plain_data(plain_data),
        .code_ready(code_ready), .code_wr_en(code_wr_en),
        .code_data_a(code_data_a), .code_data_b(code_data_b),
        .state(state)
    );

    task automatic chk(input bit ok, input string req, input string act, input string expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%s expected=%s", req, act, expv);
        end
    endtask

    // FIFO models: one cycle read latency, empty flags updated at the edge.
    always @(posedge clk) begin
        if (a_rd_en && rst_n) begin
            if (qa.size() > 0) a_rdata <= qa.pop_front();
            else chk(0, "R9 A popped while empty", "empty", "data");
        end
        if (b_rd_en && rst_n) begin
            if (qb.size() > 0) b_rdata <= qb.pop_front();
            else chk(0, "R9 B popped while empty", "empty", "data");
        end
        a_empty <= (qa.size() == 0);
        b_empty <= (qb.size() == 0);
    end

    // Monitor: compares every write against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n) begin
            if (plain_wr_en || code_wr_en) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R10 unexpected write", "write", "none");
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (plain_wr_en) begin
                        chk(!e.coded && plain_data == {8'h00, 1'b0, e.a},
                            e.coded ? "R10 plain write for coded item" : "R3/R4 plain word",
                            $sformatf("%h", plain_data), $sformatf("%h", {8'h00, 1'b0, e.a}));
                        chk(plain_ready, "R6 plain write without ready", "0", "1");
                    end else begin
                        chk(e.coded && code_data_a == {8'h00, 1'b1, e.a} && code_data_b == {8'h00, 1'b1, e.b},
                            "R5 coded pair",
                            $sformatf("%h/%h", code_data_a, code_data_b),
                            $sformatf("%h/%h", {8'h00, 1'b1, e.a}, {8'h00, 1'b1, e.b}));
                        chk(code_ready, "R6 code write without ready", "0", "1");
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1;
            chk(0, "watchdog", "timeout", "finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic push_a(input logic [63:0] d);
        qa.push_back(d);
        exp_q.push_back('{coded: 1'b0, a: d, b: 64'h0});
    endtask

    task automatic push_b(input logic [63:0] d);
        qb.push_back(d);
        exp_q.push_back('{coded: 1'b0, a: d, b: 64'h0});
    endtask

    task automatic push_pair(input logic [63:0] da, input logic [63:0] db);
        qa.push_back(da);
        qb.push_back(db);
        exp_q.push_back('{coded: 1'b1, a: da, b: db});
    endtask

    task automatic drain(input string req);
        int n = 0;
        while ((exp_q.size() != 0 || state != 3'd0) && n < 300) begin
            @(negedge clk);
            n++;
        end
        chk(exp_q.size() == 0 && state == 3'd0, req,
            $sformatf("left=%0d state=%0d", exp_q.size(), state), "left=0 state=0");
        tick();
    endtask

    // R8: follow one word through the states.
    task automatic trace(input logic [2:0] take_code, input string req);
        int n = 0;
        @(negedge clk);
        while (!(a_rd_en || b_rd_en) && n < 50) begin
            @(negedge clk);
            n++;
        end
        chk(state == 3'd0, {req, " idle at read"}, $sformatf("%0d", state), "0");
        @(negedge clk);
        chk(state == take_code, {req, " read state"}, $sformatf("%0d", state), $sformatf("%0d", take_code));
        @(negedge clk);
        chk(state == 3'd4, {req, " hold state"}, $sformatf("%0d", state), "4");
    endtask

    initial begin
        bit seen;

        // R1: reset state.
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(state == 3'd0 && !a_rd_en && !b_rd_en && !plain_wr_en && !code_wr_en,
            "R1 reset outputs", $sformatf("st=%0d", state), "st=0 all low");
        tick();
        rst_n = 1'b1;
        @(negedge clk);
        chk(state == 3'd0 && !a_rd_en && !b_rd_en && !plain_wr_en && !code_wr_en,
            "R1 after reset", $sformatf("st=%0d", state), "st=0 all low");
        tick();
        plain_ready = 1'b1;
        code_ready  = 1'b1;

        // R3 + R8: single A word.
        push_a(64'hA1A1_0000_0000_0001);
        trace(3'd1, "R8 A");
        drain("R3 single A drained");

        // R4 + R8: single B word.
        push_b(64'hB2B2_0000_0000_0002);
        trace(3'd2, "R8 B");
        drain("R4 single B drained");

        // R2 + R5 + R8: a pair.
        push_pair(64'hC0DE_0000_0000_00A0, 64'hC0DE_0000_0000_00B0);
        trace(3'd3, "R8 pair");
        drain("R2 pair drained");

        // R3: burst on A only.
        for (int i = 0; i < 4; i++) push_a(64'hAAAA_0000_0000_0010 + 64'(i));
        drain("R3 burst A drained in order");

        // R4: burst on B only.
        for (int i = 0; i < 3; i++) push_b(64'hBBBB_0000_0000_0020 + 64'(i));
        drain("R4 burst B drained in order");

        // R2 + R5: burst of pairs.
        for (int i = 0; i < 3; i++)
            push_pair(64'h1111_0000_0000_0000 + 64'(i), 64'h2222_0000_0000_0000 + 64'(i));
        drain("R5 pair burst drained in order");

        // R7: plain path not ready, A waiting, no read.
        plain_ready = 1'b0;
        push_a(64'hDEAD_0000_0000_0030);
        seen = 0;
        repeat (6) begin
            @(negedge clk);
            if (a_rd_en || b_rd_en) seen = 1;
        end
        chk(!seen, "R7 no read while plain not ready", "read", "no read");
        tick();
        plain_ready = 1'b1;
        drain("R7 released word drained");

        // R10 + R7: ready drops while a word is held; a second word waits.
        push_a(64'hFEED_0000_0000_0040);
        begin
            int n = 0;
            @(negedge clk);
            while (!a_rd_en && n < 50) begin
                @(negedge clk);
                n++;
            end
        end
        tick();
        plain_ready = 1'b0;
        push_a(64'hFEED_0000_0000_0041);
        seen = 0;
        repeat (6) begin
            @(negedge clk);
            if (plain_wr_en || a_rd_en || b_rd_en) seen = 1;
        end
        chk(!seen && state == 3'd4, "R10 word held while not ready",
            $sformatf("activity=%0d st=%0d", seen, state), "activity=0 st=4");
        chk(plain_data == {8'h00, 1'b0, 64'hFEED_0000_0000_0040}, "R10 held word unchanged",
            $sformatf("%h", plain_data), $sformatf("%h", {8'h00, 1'b0, 64'hFEED_0000_0000_0040}));
        tick();
        plain_ready = 1'b1;
        drain("R10 held words drained in order");

        // R11: both non-empty, coding blocked, plain free: full stall.
        code_ready = 1'b0;
        push_pair(64'h5555_0000_0000_0050, 64'h6666_0000_0000_0060);
        seen = 0;
        repeat (6) begin
            @(negedge clk);
            if (a_rd_en || b_rd_en || plain_wr_en) seen = 1;
        end
        chk(!seen && state == 3'd0, "R11 no fallback to plain",
            $sformatf("activity=%0d st=%0d", seen, state), "activity=0 st=0");
        tick();
        code_ready = 1'b1;
        drain("R11 pair coded after release");

        // R5 + R10: coded pair held while coding path drops ready.
        push_pair(64'h7777_0000_0000_0070, 64'h8888_0000_0000_0080);
        begin
            int n = 0;
            @(negedge clk);
            while (!a_rd_en && n < 50) begin
                @(negedge clk);
                n++;
            end
        end
        tick();
        code_ready = 1'b0;
        seen = 0;
        repeat (4) begin
            @(negedge clk);
            if (code_wr_en || plain_wr_en) seen = 1;
        end
        chk(!seen && state == 3'd4, "R6 coded pair waits for ready",
            $sformatf("activity=%0d st=%0d", seen, state), "activity=0 st=4");
        tick();
        code_ready = 1'b1;
        drain("R5 held pair written");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule